// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor core built around a single accumulator. It runs a fixed fetch, decode and execute cycle in which exactly one register transfer happens per clock step. A control state machine sequences the transfers between an instruction pointer, a memory address latch, a memory data latch, an instruction latch and the accumulator. An adder sits between the accumulator and the memory data latch.

Every memory access goes through the address and data latches over one single-port memory interface. Reads are combinational on the memory side. The data latch captures the read word on the clock edge that ends the cycle in which the read strobe is high. The instruction word is 8 bits wide. Bits [7:5] hold the opcode and bits [4:0] hold a memory address, so the core can reach 32 words. The instruction set is load, add, halt and no-op.

Top module: `acpu_core`

## Requirements
- R1: A synchronous reset clears the instruction pointer, both memory latches, the instruction latch and the accumulator to zero and starts the fetch sequence. While reset is held, `mem_addr` is 0, `acc` is 0, and `halted`, `mem_rd` and `mem_wr` are low.
- R2: Fetch is the same for every instruction and takes four steps: address latch from the pointer, pointer plus one, read into the data latch, instruction latch from the data latch. Decode follows. The first fetch read occurs on the second clock edge after reset is released, at address 0.
- R3: Bits [7:5] of an instruction are the opcode (000 halt, 001 load, 010 add) and bits [4:0] are the operand address.
- R4: Load puts the operand into the address latch, reads that word, and then copies it into the accumulator. The data read happens 4 cycles after the fetch read, and the next fetch read happens 4 cycles after the data read.
- R5: Add reads the operand word with the same timing as load and writes accumulator plus word back to the accumulator, modulo 256.
- R6: Opcodes 011 through 111 are no-ops. They make no data read and leave the accumulator unchanged, and the next fetch read follows 5 cycles after their own fetch read.
- R7: Halt raises `halted` 3 cycles after its fetch read. After that there are no more reads, the accumulator stays unchanged, and `halted` stays high until reset.
- R8: The write strobe `mem_wr` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 5 | Memory address, driven from the address latch |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle the read strobe is high |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, driven from the accumulator |
| acc | output | 8 | Accumulator value |
| halted | output | 1 | High while the core is stopped |

## Verification
Each result has a fixed distance in clock edges from an earlier event. The first fetch read comes 2 edges after reset release. A data read comes 4 edges after a load or add fetch read, the next fetch read comes 4 edges after a data read, a no-op's successor fetch comes 5 edges after its fetch, and `halted` rises 3 edges after the halt's fetch read. The scoreboard stores each expected read with its address, the accumulator value that must be visible at that moment, and its edge distance from the previous read. It compares all three on the falling edge of every cycle in which the read strobe is high. The final accumulator value and the persistence of the halt are checked after the core stops.

// File: rtl/acpu_pkg.sv
package acpu_pkg;

  parameter int unsigned WORD_W    = 8;
  parameter int unsigned OPC_W     = 3;
  parameter int unsigned ARG_W     = WORD_W - OPC_W;
  parameter int unsigned MEM_WORDS = 1 << ARG_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ARG_W-1:0]  addr_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OPC_HALT = opc_t'(0);
  localparam opc_t OPC_LOAD = opc_t'(1);
  localparam opc_t OPC_ADD  = opc_t'(2);

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_STEP,
    ST_F_READ,
    ST_F_LOAD,
    ST_DECODE,
    ST_X_ADDR,
    ST_X_READ,
    ST_X_WB,
    ST_HALT
  } state_t;

  typedef struct packed {
    logic mar_from_pc;
    logic pc_step;
    logic mem_read;
    logic ir_from_mdr;
    logic mar_from_arg;
    logic a_from_mdr;
    logic a_from_alu;
  } ctl_t;

  function automatic opc_t opc_of(word_t w);
    return w[WORD_W-1 -: OPC_W];
  endfunction

  function automatic addr_t arg_of(word_t w);
    return w[ARG_W-1:0];
  endfunction

  function automatic addr_t next_pc(addr_t p);
    return addr_t'(p + addr_t'(1));
  endfunction

  function automatic word_t wrap_sum(word_t a, word_t b);
    return word_t'(a + b);
  endfunction

endpackage

// File: rtl/acpu_alu.sv
module acpu_alu
  import acpu_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end

endmodule

// File: rtl/acpu_ctrl.sv
module acpu_ctrl
  import acpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  opc_t   opcode,
  output ctl_t   ctl,
  output state_t state
);

  state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F_ADDR;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_F_ADDR: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_F_STEP;
      end
      ST_F_STEP: begin
        ctl.pc_step = 1'b1;
        nxt = ST_F_READ;
      end
      ST_F_READ: begin
        ctl.mem_read = 1'b1;
        nxt = ST_F_LOAD;
      end
      ST_F_LOAD: begin
        ctl.ir_from_mdr = 1'b1;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        case (opcode)
          OPC_HALT: nxt = ST_HALT;
          OPC_LOAD: nxt = ST_X_ADDR;
          OPC_ADD:  nxt = ST_X_ADDR;
          default:  nxt = ST_F_ADDR;
        endcase
      end
      ST_X_ADDR: begin
        ctl.mar_from_arg = 1'b1;
        nxt = ST_X_READ;
      end
      ST_X_READ: begin
        ctl.mem_read = 1'b1;
        nxt = ST_X_WB;
      end
      ST_X_WB: begin
        if (opcode == OPC_LOAD) ctl.a_from_mdr = 1'b1;
        else                    ctl.a_from_alu = 1'b1;
        nxt = ST_F_ADDR;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F_ADDR;
    endcase
  end

endmodule

// File: rtl/acpu_regs.sv
module acpu_regs
  import acpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctl_t  ctl,
  input  word_t rdata,
  input  word_t alu_sum,
  output addr_t pc,
  output addr_t mar,
  output word_t mdr,
  output word_t ir,
  output word_t acc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_arg) mar <= arg_of(ir);
      if (ctl.pc_step)           pc  <= next_pc(pc);
      if (ctl.mem_read)          mdr <= rdata;
      if (ctl.ir_from_mdr)       ir  <= mdr;
      if (ctl.a_from_mdr)        acc <= mdr;
      else if (ctl.a_from_alu)   acc <= alu_sum;
    end
  end

endmodule

// File: rtl/acpu_core.sv
module acpu_core
  import acpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ARG_W-1:0]  mem_addr,
  output logic              mem_rd,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] acc,
  output logic              halted
);

  ctl_t   ctl;
  state_t state;
  addr_t  pc;
  addr_t  mar;
  word_t  mdr;
  word_t  ir;
  word_t  acc_q;
  word_t  sum;

  // Named events for the checker
  logic fetch_rd_ev;
  logic ld_commit;
  logic add_commit;

  acpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opc_of(ir)),
    .ctl    (ctl),
    .state  (state)
  );

  acpu_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .rdata   (mem_rdata),
    .alu_sum (sum),
    .pc      (pc),
    .mar     (mar),
    .mdr     (mdr),
    .ir      (ir),
    .acc     (acc_q)
  );

  acpu_alu #(.W(WORD_W)) u_alu (
    .a   (acc_q),
    .b   (mdr),
    .sum (sum)
  );

  assign fetch_rd_ev = ctl.mem_read && (state == ST_F_READ);
  assign ld_commit   = ctl.a_from_mdr;
  assign add_commit  = ctl.a_from_alu;

  assign mem_addr  = mar;
  assign mem_rd    = ctl.mem_read;
  assign mem_wr    = 1'b0;
  assign mem_wdata = acc_q;
  assign acc       = acc_q;
  assign halted    = (state == ST_HALT);

endmodule

// File: rtl/acpu_core_chk.sv
module acpu_core_chk
  import acpu_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  mem_rd,
  input addr_t mem_addr,
  input word_t acc,
  input logic  halted,
  input addr_t pc,
  input word_t mdr,
  input logic  fetch_rd_ev,
  input logic  ld_commit,
  input logic  add_commit
);

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r7_halt_no_read: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_rd);

  a_r7_acc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc));

  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    fetch_rd_ev |-> (mem_addr == addr_t'(pc - addr_t'(1))));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (pc != $past(pc))) |-> (pc == addr_t'($past(pc) + addr_t'(1))));

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    ld_commit |=> (acc == $past(mdr)));

  a_r5_add: assert property (@(posedge clk) disable iff (rst)
    add_commit |=> (acc == wrap_sum($past(acc), $past(mdr))));

  a_r6_acc_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (acc != $past(acc))) |-> $past(ld_commit || add_commit));

endmodule

bind acpu_core acpu_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .acc         (acc),
  .halted      (halted),
  .pc          (pc),
  .mdr         (mdr),
  .fetch_rd_ev (fetch_rd_ev),
  .ld_commit   (ld_commit),
  .add_commit  (add_commit)
);

// File: tb/acpu_core_test.sv
module acpu_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] mem_addr;
  logic       mem_rd;
  logic [7:0] mem_rdata;
  logic       mem_wr;
  logic [7:0] mem_wdata;
  logic [7:0] acc;
  logic       halted;

  logic [7:0] mem [0:31];

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int last_read = 0;
  bit halt_seen = 0;

  typedef struct {
    logic [4:0] addr;
    logic [7:0] acc;
    int         gap;
    string      req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  acpu_core uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .acc       (acc),
    .halted    (halted)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_read(logic [4:0] a, logic [7:0] v, int gap, string req);
    item_t it;
    it.addr = a; it.acc = v; it.gap = gap; it.req = req;
    sb.push_back(it);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
  endtask

  task automatic check_reset();
    chk(mem_addr == 5'd0, "R1", "reset mem_addr", int'(mem_addr), 0);
    chk(acc == 8'd0,      "R1", "reset acc", int'(acc), 0);
    chk(!halted,          "R1", "reset halted", int'(halted), 0);
    chk(!mem_rd,          "R1", "reset mem_rd", int'(mem_rd), 0);
    chk(!mem_wr,          "R1", "reset mem_wr", int'(mem_wr), 0);
  endtask

  task automatic wait_halt(int limit);
    int n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(halted, "R7", "halt reached before timeout", int'(halted), 1);
  endtask

  // Edge counter since reset release
  always @(posedge clk) begin
    if (rst) edges = 0;
    else     edges = edges + 1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      last_read = 0;
      halt_seen = 0;
    end else begin
      if (mem_wr) chk(1'b0, "R8", "write strobe", 1, 0);
      if (mem_rd) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "unexpected read at addr", int'(mem_addr), -1);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(mem_addr == it.addr, it.req, "read address", int'(mem_addr), int'(it.addr));
          chk(acc == it.acc, it.req, "acc at read", int'(acc), int'(it.acc));
          chk((edges - last_read) == it.gap, it.req, "read spacing", edges - last_read, it.gap);
        end
        last_read = edges;
      end
      if (halted && !halt_seen) begin
        halt_seen = 1;
        chk((edges - last_read) == 3, "R7", "halt delay", edges - last_read, 3);
      end
    end
  end

  function automatic logic [7:0] add8(logic [7:0] a, logic [7:0] b);
    int s;
    s = (int'(a) + int'(b)) % 256;
    return s[7:0];
  endfunction

  initial begin
    logic [7:0] a1;
    logic [7:0] a2;
    logic [7:0] a3;

    // Program 1: load, add, no-op, add with wrap, halt
    clear_mem();
    mem[0]  = 8'h34;  // R3: 001_10100 load 20
    mem[1]  = 8'h55;  // add 21
    mem[2]  = 8'hE0;  // opcode 111: no-op
    mem[3]  = 8'h56;  // add 22
    mem[4]  = 8'h00;  // halt
    mem[20] = 8'h37;
    mem[21] = 8'h41;
    mem[22] = 8'hF0;
    a1 = 8'h37;
    a2 = add8(a1, 8'h41);
    a3 = add8(a2, 8'hF0);

    expect_read(5'd0,  8'h00, 2, "R2");
    expect_read(5'd20, 8'h00, 4, "R4");
    expect_read(5'd1,  a1,    4, "R4");
    expect_read(5'd21, a1,    4, "R5");
    expect_read(5'd2,  a2,    4, "R5");
    expect_read(5'd3,  a2,    5, "R6");
    expect_read(5'd22, a2,    4, "R5");
    expect_read(5'd4,  a3,    4, "R5");

    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    wait_halt(300);
    chk(acc == a3, "R5", "final acc wraps", int'(acc), int'(a3));
    chk(sb.size() == 0, "R2", "reads left in scoreboard", sb.size(), 0);
    repeat (20) @(negedge clk);
    chk(halted, "R7", "halt persists", int'(halted), 1);
    chk(acc == a3, "R7", "acc frozen while halted", int'(acc), int'(a3));

    // Reset after halt, then program 2: several no-op codes, edge addresses
    rst = 1'b1;
    clear_mem();
    mem[0]  = 8'h7F;  // opcode 011 no-op with operand 31
    mem[1]  = 8'h3F;  // load 31
    mem[2]  = 8'h65;  // opcode 011 no-op
    mem[3]  = 8'h5E;  // add 30
    mem[4]  = 8'h80;  // opcode 100 no-op
    mem[5]  = 8'hA0;  // opcode 101 no-op
    mem[6]  = 8'hC3;  // opcode 110 no-op
    mem[7]  = 8'h1F;  // halt with operand bits set
    mem[30] = 8'h02;
    mem[31] = 8'hFF;
    @(negedge clk);
    check_reset();
    a1 = 8'hFF;
    a2 = add8(a1, 8'h02);

    expect_read(5'd0,  8'h00, 2, "R2");
    expect_read(5'd1,  8'h00, 5, "R6");
    expect_read(5'd31, 8'h00, 4, "R4");
    expect_read(5'd2,  a1,    4, "R4");
    expect_read(5'd3,  a1,    5, "R6");
    expect_read(5'd30, a1,    4, "R5");
    expect_read(5'd4,  a2,    4, "R5");
    expect_read(5'd5,  a2,    5, "R6");
    expect_read(5'd6,  a2,    5, "R6");
    expect_read(5'd7,  a2,    5, "R6");

    @(negedge clk);
    rst = 1'b0;
    wait_halt(300);
    chk(acc == a2, "R5", "program 2 final acc", int'(acc), int'(a2));
    chk(sb.size() == 0, "R6", "reads left in scoreboard", sb.size(), 0);
    repeat (10) @(negedge clk);
    chk(halted, "R7", "halt persists after program 2", int'(halted), 1);
    chk(mem_wdata == a2, "R8", "write data idle value", int'(mem_wdata), int'(a2));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule